// File: doc/BRIEF.md
# Task-File Shadow Registers

This block is the register file on the device side of an ATA-style host register bus. The host issues byte writes, each with a three-bit register address and a write strobe. The block loads the features, sector count, three address bytes, device and command registers from those writes. The address bytes, the count byte and the features byte each keep the two most recent values written to them. This lets a 48-bit block address and 16-bit count and feature words be assembled from two writes per register.

A write to the command register produces a single-cycle command strobe that carries the opcode. The opcode also selects the addressing width. The extended read and write opcodes select 48-bit addressing, and every other opcode selects 28-bit addressing, in which the top address nibble is taken from the device register. Downstream command logic uses the assembled address, the count, the device-select bit and the LBA-mode bit together with the strobe.

Top module: `tf_shadow_regs`

## Requirements
- R1: While reset is asserted and right after it is released, every stored byte is zero, `cmd_valid` is low, `lba_wide` is low and `lba_addr`, `sect_count`, `feature_word`, `dev_reg` and `cmd_opcode` all read zero.
- R2: A write to address 1 to 5 moves that register's newer byte into its older slot and stores the written byte as the newer one. The other registers are left unchanged.
- R3: While `lba_wide` is high, `lba_addr` is the older High, older Mid, older Low, newer High, newer Mid and newer Low bytes, from bit 47 down to bit 0. Writing 0x56, 0xEF to Low, 0x34, 0xCD to Mid and 0x12, 0xAB to High therefore gives 0x123456ABCDEF.
- R4: While `lba_wide` is low, `lba_addr` has bits 47:28 at zero, bits 27:24 equal to `dev_reg[3:0]`, and bits 23:0 equal to newer High, newer Mid and newer Low.
- R5: While `lba_wide` is high, `sect_count` and `feature_word` are {older, newer} byte. While it is low, they are {0x00, newer}.
- R6: A write to address 6 stores all eight bits in `dev_reg`, including the obsolete bits 7 and 5. `dev_sel` equals bit 4 (device 1 when set), and `lba_mode` equals bit 6.
- R7: A write to address 7 makes `cmd_valid` high for the one cycle after the write edge, with `cmd_opcode` equal to the written byte. Back-to-back command writes give back-to-back strobes, each carrying its own opcode.
- R8: A command write sets `lba_wide` when the opcode is 0x24 or 0x34 and clears it for any other opcode. The value holds until the next command write.
- R9: The register address map is 1 features, 2 count, 3 LBA Low, 4 LBA Mid, 5 LBA High, 6 device, 7 command. A write to address 0, or any cycle with `wr_en` low, changes no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one byte |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Byte written |
| lba_addr | output | 48 | Assembled block address (48-bit or 28-bit form) |
| sect_count | output | 16 | Assembled sector count |
| feature_word | output | 16 | Assembled features value |
| dev_reg | output | 8 | Device register as written |
| dev_sel | output | 1 | Device 1 selected |
| lba_mode | output | 1 | LBA addressing requested |
| lba_wide | output | 1 | 48-bit addressing in force |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_opcode | output | 8 | Opcode of the latest command |

## Verification
The command strobe and the addressing-mode switch can fall in the same cycle as a new register load. The most demanding case is two command writes on consecutive cycles, where the strobe stays high across two cycles while the opcode and the width flag change under it. The bench provokes this with an extended opcode followed directly by a plain one, and then with a plain opcode followed directly by an extended one. In each strobe cycle it compares the opcode, the width flag and the re-assembled address against a byte model kept in the bench.

// File: rtl/tf_pkg.sv
package tf_pkg;
  localparam int BYTE_W   = 8;
  localparam int NIB_W    = BYTE_W / 2;
  localparam int WIDE_W   = 2 * BYTE_W;
  localparam int LBA_W    = 6 * BYTE_W;
  localparam int NUM_HIST = 5;
  localparam int NUM_REG  = 7;

  // register index = bus address - 1
  localparam int IX_FEAT = 0;
  localparam int IX_CNT  = 1;
  localparam int IX_LOW  = 2;
  localparam int IX_MID  = 3;
  localparam int IX_HIGH = 4;
  localparam int IX_DEV  = 5;
  localparam int IX_CMD  = 6;

  localparam logic [BYTE_W-1:0] OP_RD_EXT = 8'h24;
  localparam logic [BYTE_W-1:0] OP_WR_EXT = 8'h34;

  localparam int DEV_SEL_BIT = 4;
  localparam int DEV_LBA_BIT = 6;

  typedef logic [BYTE_W-1:0] byte_t;

  function automatic logic opcode_is_wide(input byte_t op);
    return (op == OP_RD_EXT) || (op == OP_WR_EXT);
  endfunction

  function automatic logic [LBA_W-1:0] lba_from_pairs(
    input byte_t lo_old, input byte_t mi_old, input byte_t hi_old,
    input byte_t lo_new, input byte_t mi_new, input byte_t hi_new);
    return {hi_old, mi_old, lo_old, hi_new, mi_new, lo_new};
  endfunction

  function automatic logic [LBA_W-1:0] lba_from_nibble(
    input logic [NIB_W-1:0] nib,
    input byte_t lo_new, input byte_t mi_new, input byte_t hi_new);
    return {{(LBA_W - 3*BYTE_W - NIB_W){1'b0}}, nib, hi_new, mi_new, lo_new};
  endfunction

  function automatic logic [WIDE_W-1:0] join_word(
    input logic wide, input byte_t older, input byte_t newer);
    return wide ? {older, newer} : {{BYTE_W{1'b0}}, newer};
  endfunction
endpackage

// File: rtl/tf_hist_byte.sv
module tf_hist_byte #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur  <= '0;
      prev <= '0;
    end else if (load) begin
      prev <= cur;
      cur  <= din;
    end
  end
endmodule

// File: rtl/tf_addr_decode.sv
module tf_addr_decode #(
  parameter int ADDR_W = 3,
  parameter int N_REG  = 7
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [N_REG-1:0]  sel
);
  // register i answers to bus address i+1; address 0 selects nothing
  for (genvar i = 0; i < N_REG; i++) begin : g_sel
    assign sel[i] = wr_en && (wr_addr == ADDR_W'(i + 1));
  end
endmodule

// File: rtl/tf_cmd_unit.sv
module tf_cmd_unit
  import tf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  byte_t din,
  output logic  valid,
  output byte_t opcode,
  output logic  wide
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      opcode <= '0;
      wide   <= 1'b0;
    end else begin
      valid <= load;
      if (load) begin
        opcode <= din;
        wide   <= opcode_is_wide(din);
      end
    end
  end
endmodule

// File: rtl/tf_lba_build.sv
module tf_lba_build
  import tf_pkg::*;
(
  input  logic             wide,
  input  byte_t            lo_new,
  input  byte_t            mi_new,
  input  byte_t            hi_new,
  input  byte_t            lo_old,
  input  byte_t            mi_old,
  input  byte_t            hi_old,
  input  logic [NIB_W-1:0] dev_nib,
  output logic [LBA_W-1:0] lba
);
  logic [LBA_W-1:0] lba48, lba28;
  assign lba48 = lba_from_pairs(lo_old, mi_old, hi_old, lo_new, mi_new, hi_new);
  assign lba28 = lba_from_nibble(dev_nib, lo_new, mi_new, hi_new);
  assign lba   = wide ? lba48 : lba28;
endmodule

// File: rtl/tf_shadow_regs.sv
module tf_shadow_regs
  import tf_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic [47:0]       lba_addr,
  output logic [15:0]       sect_count,
  output logic [15:0]       feature_word,
  output logic [7:0]        dev_reg,
  output logic              dev_sel,
  output logic              lba_mode,
  output logic              lba_wide,
  output logic              cmd_valid,
  output logic [7:0]        cmd_opcode
);
  logic [NUM_REG-1:0] sel;
  byte_t hcur  [NUM_HIST];
  byte_t hprev [NUM_HIST];
  byte_t dev_q;

  // named internal events for the checker
  logic  low_load;
  byte_t low_cur_w, low_prev_w;

  tf_addr_decode #(.ADDR_W(ADDR_W), .N_REG(NUM_REG)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .sel(sel)
  );

  for (genvar g = 0; g < NUM_HIST; g++) begin : g_hist
    tf_hist_byte #(.W(BYTE_W)) u_hist (
      .clk(clk), .rst_n(rst_n), .load(sel[g]), .din(wr_data),
      .cur(hcur[g]), .prev(hprev[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          dev_q <= '0;
    else if (sel[IX_DEV]) dev_q <= wr_data;
  end

  tf_cmd_unit u_cmd (
    .clk(clk), .rst_n(rst_n), .load(sel[IX_CMD]), .din(wr_data),
    .valid(cmd_valid), .opcode(cmd_opcode), .wide(lba_wide)
  );

  tf_lba_build u_lba (
    .wide(lba_wide),
    .lo_new(hcur[IX_LOW]),  .mi_new(hcur[IX_MID]),  .hi_new(hcur[IX_HIGH]),
    .lo_old(hprev[IX_LOW]), .mi_old(hprev[IX_MID]), .hi_old(hprev[IX_HIGH]),
    .dev_nib(dev_q[NIB_W-1:0]),
    .lba(lba_addr)
  );

  assign sect_count   = join_word(lba_wide, hprev[IX_CNT],  hcur[IX_CNT]);
  assign feature_word = join_word(lba_wide, hprev[IX_FEAT], hcur[IX_FEAT]);
  assign dev_reg      = dev_q;
  assign dev_sel      = dev_q[DEV_SEL_BIT];
  assign lba_mode     = dev_q[DEV_LBA_BIT];

  assign low_load   = sel[IX_LOW];
  assign low_cur_w  = hcur[IX_LOW];
  assign low_prev_w = hprev[IX_LOW];
endmodule

// File: rtl/tf_shadow_regs_chk.sv
module tf_shadow_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [2:0]  wr_addr,
  input logic [7:0]  wr_data,
  input logic [47:0] lba_addr,
  input logic [15:0] sect_count,
  input logic [15:0] feature_word,
  input logic [7:0]  dev_reg,
  input logic        lba_wide,
  input logic        cmd_valid,
  input logic [7:0]  cmd_opcode,
  input logic        low_load,
  input logic [7:0]  low_cur_w,
  input logic [7:0]  low_prev_w
);
  p_cmd_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd7) |=> (cmd_valid && cmd_opcode == $past(wr_data)));

  p_no_stray_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == 3'd7) |=> !cmd_valid);

  p_low_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    low_load |=> (low_prev_w == $past(low_cur_w) && low_cur_w == $past(wr_data)));

  p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || wr_addr == 3'd0) |=> ($stable(lba_addr) && $stable(sect_count)
      && $stable(feature_word) && $stable(dev_reg) && $stable(lba_wide)));

  p_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (lba_wide == (cmd_opcode == 8'h24 || cmd_opcode == 8'h34)));

  p_narrow_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !lba_wide |-> (lba_addr[47:28] == 20'd0 && sect_count[15:8] == 8'd0));
endmodule

bind tf_shadow_regs tf_shadow_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .lba_addr(lba_addr), .sect_count(sect_count), .feature_word(feature_word),
  .dev_reg(dev_reg), .lba_wide(lba_wide), .cmd_valid(cmd_valid),
  .cmd_opcode(cmd_opcode), .low_load(low_load), .low_cur_w(low_cur_w),
  .low_prev_w(low_prev_w)
);

// File: tb/tf_shadow_regs_tb.sv
module tf_shadow_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [47:0] lba_addr;
  logic [15:0] sect_count, feature_word;
  logic [7:0]  dev_reg, cmd_opcode;
  logic        dev_sel, lba_mode, lba_wide, cmd_valid;

  int errors = 0;
  int checks = 0;

  // bench model: index 1..5 = address
  int m_new [8];
  int m_old [8];
  int m_dev = 0;
  int m_op = 0;
  int m_wide = 0;
  int m_valid = 0;

  always #5 clk = ~clk;

  tf_shadow_regs u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .lba_addr(lba_addr), .sect_count(sect_count), .feature_word(feature_word),
    .dev_reg(dev_reg), .dev_sel(dev_sel), .lba_mode(lba_mode), .lba_wide(lba_wide),
    .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode)
  );

  task automatic chk(input string req, input string what,
                     input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic longint exp_lba();
    longint v;
    if (m_wide != 0)
      v = longint'(m_old[5]) * 64'd1099511627776 + longint'(m_old[4]) * 64'd4294967296
        + longint'(m_old[3]) * 64'd16777216 + longint'(m_new[5]) * 64'd65536
        + longint'(m_new[4]) * 64'd256 + longint'(m_new[3]);
    else
      v = longint'(m_dev % 16) * 64'd16777216 + longint'(m_new[5]) * 64'd65536
        + longint'(m_new[4]) * 64'd256 + longint'(m_new[3]);
    return v;
  endfunction

  function automatic longint exp_word(input int a);
    return (m_wide != 0) ? longint'(m_old[a] * 256 + m_new[a]) : longint'(m_new[a]);
  endfunction

  task automatic model_write(input int a, input int d);
    if (a >= 1 && a <= 5) begin
      m_old[a] = m_new[a];
      m_new[a] = d;
    end else if (a == 6) begin
      m_dev = d;
    end else if (a == 7) begin
      m_op = d;
      m_wide = (d == 36 || d == 52) ? 1 : 0;
    end
  endtask

  task automatic check_all(input string req);
    chk(req, "lba_addr", longint'(lba_addr), exp_lba());
    chk(req, "sect_count", longint'(sect_count), exp_word(2));
    chk(req, "feature_word", longint'(feature_word), exp_word(1));
    chk(req, "dev_reg", longint'(dev_reg), longint'(m_dev));
    chk(req, "dev_sel", longint'(dev_sel), longint'((m_dev / 16) % 2));
    chk(req, "lba_mode", longint'(lba_mode), longint'((m_dev / 64) % 2));
    chk(req, "lba_wide", longint'(lba_wide), longint'(m_wide));
    chk(req, "cmd_valid", longint'(cmd_valid), longint'(m_valid));
    if (m_valid != 0) chk(req, "cmd_opcode", longint'(cmd_opcode), longint'(m_op));
  endtask

  // one write, strobe dropped afterwards; sampled at the following falling edge
  task automatic wr(input int a, input int d, input bit en, input string req);
    @(negedge clk);
    wr_en = en; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
    if (en) model_write(a, d);
    m_valid = (en && a == 7) ? 1 : 0;
    check_all(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_new[i] = 0; m_old[i] = 0; end
    repeat (3) @(negedge clk);
    m_valid = 0;
    check_all("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 after release");

    // R3 worked example
    wr(3, 8'h56, 1, "R2"); wr(3, 8'hEF, 1, "R2");
    wr(4, 8'h34, 1, "R2"); wr(4, 8'hCD, 1, "R2");
    wr(5, 8'h12, 1, "R2"); wr(5, 8'hAB, 1, "R2");
    wr(7, 8'h24, 1, "R7 R8 ext read");
    chk("R3", "example lba", longint'(lba_addr), 64'h123456ABCDEF);
    wr(7, 8'h20, 1, "R8 plain read");
    wr(6, 8'hE5, 1, "R4 R6 dev nibble");
    chk("R4", "28-bit lba", longint'(lba_addr), 64'h05ABCDEF);

    // R5 count/features both modes
    wr(2, 8'h01, 1, "R5"); wr(2, 8'h80, 1, "R5");
    wr(1, 8'h3C, 1, "R5"); wr(1, 8'hC3, 1, "R5");
    wr(7, 8'h34, 1, "R5 R8 ext write");
    chk("R5", "wide count", longint'(sect_count), 64'h0180);

    // R9 ignored writes
    wr(3, 8'h99, 0, "R9 strobe low");
    wr(0, 8'h77, 1, "R9 address zero");

    // near-exhaustive address/data sweep
    for (int a = 0; a < 8; a++)
      for (int k = 0; k < 8; k++)
        wr(a, (a * 37 + k * 29 + 5) % 256, 1, "R2 R6 R9 sweep");

    // R8 every opcode
    for (int op = 0; op < 256; op++)
      wr(7, op, 1, "R7 R8 opcode sweep");

    // R7 back-to-back command strobes: ext then plain, then plain then ext
    for (int pass = 0; pass < 2; pass++) begin
      int first, second;
      first  = (pass == 0) ? 8'h24 : 8'h30;
      second = (pass == 0) ? 8'h30 : 8'h34;
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 3'd7; wr_data = 8'(first);
      @(negedge clk);
      wr_data = 8'(second);
      model_write(7, first); m_valid = 1;
      check_all("R7 first of pair");
      @(negedge clk);
      wr_en = 1'b0;
      model_write(7, second); m_valid = 1;
      check_all("R7 second of pair");
      @(negedge clk);
      m_valid = 0;
      check_all("R7 strobe ends");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule